// File: doc/BRIEF.md
# Oscillator Stability Detector

This block judges whether a digitally controlled oscillator has settled. A measurement unit elsewhere produces a signed count-error value (measured cycles minus target cycles) and pulses a sample strobe when a new value is ready. On each strobe the detector compares the new value with the previous one. It declares the oscillator stable once the change has stayed within an unlock threshold on two strobes in a row while the clock is not reported static.

A separate activity monitor drives a static-clock flag, and power-mode logic pulses an off-state entry input. Both force the stable bit low and restart the qualification. The stable bit is exported directly and as bit 0 of an 8-bit read-only status byte. A small gate passes a pending exit-from-off request only while the bit is set. Clock-mode logic that must wait for a settled oscillator can therefore use that gated request, and a clock monitor can use the bit to decide when to begin watching the oscillator.

Top module: `osc_stable_detect`

## Requirements
- R1: After reset, `dcoStable` is 0 and `statusReg` reads 8'h00.
- R2: `statusReg` bits 7:1 always read 0, and bit 0 always equals `dcoStable`.
- R3: The first strobe after reset or after an off-state entry only stores the sample. A run therefore needs three strobes, and `dcoStable` stays 0 after the second.
- R4: A strobe counts as in-threshold when |countErr − previous sample| ≤ UNLOCK_THR (default 8). `dcoStable` rises in the cycle after the second consecutive in-threshold strobe.
- R5: A strobe whose change exceeds UNLOCK_THR clears `dcoStable` in the next cycle and restarts the run. Two more in-threshold strobes are then needed.
- R6: While `clkStatic` is 1, `dcoStable` is cleared in the next cycle and strobes do not count toward a run. Once `clkStatic` returns to 0, two in-threshold strobes are needed.
- R7: An `offEnter` pulse clears `dcoStable` in the next cycle and discards the stored sample.
- R8: The threshold is inclusive: a change of exactly UNLOCK_THR counts and UNLOCK_THR+1 breaks the run. The change is computed on the full signed 12-bit range without wrap, so a step from −2048 to 2047 is out of threshold.
- R9: `exitGo` is 1 exactly when `exitReq` is 1 and `dcoStable` is 1.
- R10: `dcoStable` does not change in a cycle with no strobe, no `clkStatic` and no `offEnter`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | New count-error sample valid |
| countErr | input | 12 | Signed count error (two's complement) |
| clkStatic | input | 1 | Activity monitor reports the oscillator clock static |
| offEnter | input | 1 | One-cycle pulse on entry to the off state |
| exitReq | input | 1 | Pending request to leave the off state into a mode that waits for stability |
| dcoStable | output | 1 | Oscillator stable flag |
| statusReg | output | 8 | Read-only status byte, stable flag in bit 0 |
| exitGo | output | 1 | Exit request released |

## Verification
The bench targets the first sample after reset and after off-state entry. A design that compared against a stale or zero previous value would declare stability one strobe early. It drives changes of exactly the threshold and one above it, so an off-by-one comparison either rejects a legal step or accepts an illegal one. It also steps between the extremes of the signed range, where a design that ignores the sign would see a tiny change and go stable. Finally, it checks that a static clock and off-state entry both clear the bit and force a complete new run, which a design that kept its run counter would skip.

// File: rtl/osc_stable_pkg.sv
package osc_stable_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadPrev;
    logic clrPrev;
  } dpStrobe_t;
endpackage

// File: rtl/osc_stable_dp.sv
module osc_stable_dp
  import osc_stable_pkg::*;
#(
  parameter int unsigned ERR_W      = 12,
  parameter int unsigned UNLOCK_THR = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [ERR_W-1:0] countErr,
  output logic             inThr,
  output logic             prevValid
);
  localparam int unsigned DIFF_W = ERR_W + 1;
  localparam logic [DIFF_W-1:0] THR_V = DIFF_W'(UNLOCK_THR);

  logic [ERR_W-1:0]  prevErr;
  logic [DIFF_W-1:0] delta;
  logic [DIFF_W-1:0] mag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevErr   <= '0;
      prevValid <= 1'b0;
    end else if (stb.clrPrev) begin
      prevValid <= 1'b0;
    end else if (stb.loadPrev) begin
      prevErr   <= countErr;
      prevValid <= 1'b1;
    end
  end

  // sign-extended difference, one extra bit so it never wraps
  always_comb begin
    delta = {countErr[ERR_W-1], countErr} - {prevErr[ERR_W-1], prevErr};
    mag   = delta[DIFF_W-1] ? (~delta + 1'b1) : delta;
    inThr = (mag <= THR_V);
  end
endmodule

// File: rtl/osc_stable_ctrl.sv
module osc_stable_ctrl
  import osc_stable_pkg::*;
#(
  parameter int unsigned RUN_LEN = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleStb,
  input  logic      clkStatic,
  input  logic      offEnter,
  input  logic      inThr,
  input  logic      prevValid,
  output dpStrobe_t stb,
  output logic      stable
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] runNext;
  logic             goodSample;
  logic             badSample;

  always_comb begin
    stb.clrPrev = offEnter;
    stb.loadPrev = sampleStb & ~offEnter;
    goodSample = sampleStb & prevValid & inThr;
    badSample  = sampleStb & prevValid & ~inThr;
    runNext    = (runCnt == RUN_MAX) ? RUN_MAX : runCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt <= '0;
      stable <= 1'b0;
    end else if (offEnter || clkStatic || badSample) begin
      runCnt <= '0;
      stable <= 1'b0;
    end else if (goodSample) begin
      runCnt <= runNext;
      if (runNext == RUN_MAX) stable <= 1'b1;
    end
  end
endmodule

// File: rtl/osc_stable_detect.sv
module osc_stable_detect
  import osc_stable_pkg::*;
#(
  parameter int unsigned ERR_W      = 12,
  parameter int unsigned UNLOCK_THR = 8,
  parameter int unsigned RUN_LEN    = 2,
  parameter int unsigned STAT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic [ERR_W-1:0]  countErr,
  input  logic              clkStatic,
  input  logic              offEnter,
  input  logic              exitReq,
  output logic              dcoStable,
  output logic [STAT_W-1:0] statusReg,
  output logic              exitGo
);
  dpStrobe_t stb;
  logic      inThr;
  logic      prevValid;

  osc_stable_dp #(.ERR_W(ERR_W), .UNLOCK_THR(UNLOCK_THR)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .countErr(countErr),
    .inThr(inThr), .prevValid(prevValid)
  );

  osc_stable_ctrl #(.RUN_LEN(RUN_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .clkStatic(clkStatic),
    .offEnter(offEnter), .inThr(inThr), .prevValid(prevValid),
    .stb(stb), .stable(dcoStable)
  );

  assign statusReg = {{(STAT_W-1){1'b0}}, dcoStable};
  assign exitGo    = exitReq & dcoStable;
endmodule

// File: rtl/osc_stable_detect_chk.sv
module osc_stable_detect_chk #(
  parameter int unsigned STAT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleStb,
  input logic              clkStatic,
  input logic              offEnter,
  input logic              dcoStable,
  input logic [STAT_W-1:0] statusReg
);
  // R7
  off_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    offEnter |=> !dcoStable);

  // R6
  static_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkStatic |=> !dcoStable);

  // R4
  rise_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dcoStable) |-> ($past(sampleStb) && !$past(clkStatic) && !$past(offEnter)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleStb && !clkStatic && !offEnter) |=> $stable(dcoStable));

  // R2
  status_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[0]) |-> $past(sampleStb));
endmodule

bind osc_stable_detect osc_stable_detect_chk #(.STAT_W(STAT_W)) chk_i (
  .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .clkStatic(clkStatic),
  .offEnter(offEnter), .dcoStable(dcoStable), .statusReg(statusReg)
);

// File: tb/osc_stable_detect_tb_top.sv
module osc_stable_detect_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStb = 1'b0;
  logic [11:0] countErr = '0;
  logic        clkStatic = 1'b0;
  logic        offEnter = 1'b0;
  logic        exitReq = 1'b0;
  logic        dcoStable;
  logic [7:0]  statusReg;
  logic        exitGo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  osc_stable_detect dut_i (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .countErr(countErr),
    .clkStatic(clkStatic), .offEnter(offEnter), .exitReq(exitReq),
    .dcoStable(dcoStable), .statusReg(statusReg), .exitGo(exitGo)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // one strobe; the result is visible at the following negedge
  task automatic smp(int val);
    @(negedge clk);
    sampleStb = 1'b1;
    countErr  = 12'(val);
    @(negedge clk);
    sampleStb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset status", statusReg, 8'h00);
    chk("R1 reset stable", {7'b0, dcoStable}, 8'h00);
  endtask

  task automatic t_firstRun();
    smp(100);
    chk("R3 after first", statusReg, 8'h00);
    smp(104);
    chk("R3 after second", statusReg, 8'h00);
    smp(98);
    chk("R4 after third", {7'b0, dcoStable}, 8'h01);
    chk("R2 status byte", statusReg, 8'h01);
  endtask

  task automatic t_holdExit();
    repeat (5) @(negedge clk);
    chk("R10 idle hold", {7'b0, dcoStable}, 8'h01);
    exitReq = 1'b1;
    #1;
    chk("R9 exit released", {7'b0, exitGo}, 8'h01);
    exitReq = 1'b0;
    #1;
    chk("R9 no request", {7'b0, exitGo}, 8'h00);
  endtask

  task automatic t_break();
    smp(120);
    chk("R5 break clears", statusReg, 8'h00);
    smp(121);
    chk("R5 one after break", statusReg, 8'h00);
    smp(125);
    chk("R5 two after break", statusReg, 8'h01);
  endtask

  task automatic t_boundary();
    smp(200);
    smp(208);
    chk("R8 exact threshold one", statusReg, 8'h00);
    smp(200);
    chk("R8 exact threshold two", statusReg, 8'h01);
    smp(209);
    chk("R8 threshold plus one", statusReg, 8'h00);
    smp(-2048);
    smp(2047);
    chk("R8 full swing", statusReg, 8'h00);
    smp(2040);
    smp(2047);
    chk("R8 top of range", statusReg, 8'h01);
  endtask

  task automatic t_static();
    @(negedge clk);
    clkStatic = 1'b1;
    @(negedge clk);
    chk("R6 static clears", statusReg, 8'h00);
    smp(2047);
    smp(2047);
    chk("R6 no count while static", statusReg, 8'h00);
    exitReq = 1'b1;
    #1;
    chk("R9 held while unstable", {7'b0, exitGo}, 8'h00);
    exitReq = 1'b0;
    clkStatic = 1'b0;
    smp(2047);
    chk("R6 one after static", statusReg, 8'h00);
    smp(2047);
    chk("R6 two after static", statusReg, 8'h01);
  endtask

  task automatic t_off();
    @(negedge clk);
    offEnter = 1'b1;
    @(negedge clk);
    offEnter = 1'b0;
    chk("R7 off clears", statusReg, 8'h00);
    smp(2047);
    smp(2047);
    chk("R7 R3 stored sample dropped", statusReg, 8'h00);
    smp(2047);
    chk("R7 third after off", statusReg, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_firstRun();
    t_holdExit();
    t_break();
    t_boundary();
    t_static();
    t_off();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule